// File: doc/BRIEF.md
# Smart-Card Character Transmitter with Error-Signal Detection

This block sends bytes over the single-wire, half-duplex character link used by smart cards. The host enables the link and hands bytes over through a valid/ready handshake into a one-entry holding slot. Whenever the slot is full and both enables are set, the byte moves into the frame engine. The engine then drives a frame made of a low start bit, eight data bits, a parity bit and a high stop/guard period. Each bit lasts one elementary time unit (ETU), which is a fixed number of system clocks.

During the first guard ETU, the block samples the receive line once, at its midpoint. If the card holds the line low there, the block treats this as the card signalling a parity error and sets a sticky error flag. The flag stays set until the host clears it with a write-one-to-clear strobe.

Two bit conventions are available. In the direct convention, data goes out least significant bit first as plain levels. In the inverse convention, data goes out most significant bit first with every level inverted. In both conventions the parity bit is chosen so that the line shows an even number of ones. At the end of each frame the block raises a transmit-empty flag and a one-clock interrupt pulse. If another byte is already waiting, its start bit follows the last guard ETU with no idle clock in between. A transfer clock output rests high whenever the link is idle.

Top module: `sc_uart_tx`

## Requirements
- R1: After reset, `tx_line`, `sck`, `txe` and `in_ready` are 1, and `tx_irq` and `par_err` are 0.
- R2: The holding slot takes `in_data` on a clock where `in_valid` and `in_ready` are both 1. `in_ready` is then 0 until the byte has moved into the frame engine.
- R3: A frame starts only on a clock where the slot is full and both `tx_en` and `rx_en` are 1. In the next cycle `txe` is 0 and `tx_line` carries the low start bit.
- R4: Each line bit is held for exactly ETU_CLKS clocks.
- R5: With `inv_fmt`=0, the frame is: start (0), data bit 0 up to bit 7 as plain levels, parity, then STOP_ETU ETUs at level 1. The line idles at 1.
- R6: The line parity bit makes the count of ones in the nine line bits (eight data bits plus parity) even.
- R7: With `inv_fmt`=1, which is sampled when a frame starts, data goes out bit 7 down to bit 0, each bit inverted.
- R8: In the cycle after a frame's last clock, `tx_irq` is 1 for exactly one cycle. `txe` goes to 1 unless another frame starts at that point.
- R9: If the next frame may start at the end of a frame, its start bit appears in the cycle right after the last guard clock, with no idle clock.
- R10: `rx_line` is sampled once per frame, at clock ETU_CLKS/2 of the first guard ETU (10*ETU_CLKS + ETU_CLKS/2 clocks after the start bit began). A low level there sets `par_err` on the next cycle. Low levels at any other clock have no effect.
- R11: `par_err` holds until a cycle with `err_clr`=1 clears it. A new error on the same clock as `err_clr` leaves it set.
- R12: `sck` is 1 while idle. Within a frame it is 1 in the first half of each ETU and 0 in the second half, delayed by one clock.
- R13: Clearing `tx_en` or `rx_en` during a frame does not shorten or stop that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable (must also be set for a frame to start) |
| inv_fmt | input | 1 | 1 selects the inverse convention |
| in_data | input | 8 | Byte offered to the holding slot |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Holding slot is empty |
| rx_line | input | 1 | Receive line level, sampled for the card's error signal |
| err_clr | input | 1 | Write-one-to-clear strobe for `par_err` |
| tx_line | output | 1 | Serial output |
| sck | output | 1 | Transfer clock, high at rest |
| txe | output | 1 | Frame engine holds no unsent character |
| tx_irq | output | 1 | One-clock pulse at each frame end |
| par_err | output | 1 | Sticky error flag |

## Verification
The bound checker watches several properties on every clock:
- the start condition and the low start bit;
- the line level and `sck` while idle;
- the single-cycle interrupt pulse and its link to a chained start bit;
- the handshake closing the slot;
- the stickiness of the error flag.

Other behaviour only shows in the bench's scenarios, which compare every output against a behavioural model on each clock and also capture frames bit by bit at mid-ETU:
- the exact bit order and inversion of both conventions;
- the parity value;
- the ETU length;
- the one-clock error window, including the clocks just before and just after it;
- the precedence of a new error over the clear strobe;
- frames that keep running after the enables drop.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;

  localparam int SC_DATA_W = 8;

  typedef logic [SC_DATA_W-1:0] sc_byte_t;

  // Returns the data bits in the order they leave the line (bit 0 first).
  function automatic sc_byte_t sc_line_word(input sc_byte_t d, input logic inv);
    sc_byte_t w;
    for (int i = 0; i < SC_DATA_W; i++) begin
      w[i] = inv ? ~d[SC_DATA_W-1-i] : d[i];
    end
    return w;
  endfunction

  // Line-level parity bit; for an even data width it is the same in both conventions.
  function automatic logic sc_line_parity(input sc_byte_t d);
    return ^d;
  endfunction

endpackage

// File: rtl/sc_hold_buf.sv
module sc_hold_buf
  import sc_tx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  sc_byte_t wr_data,
  input  logic     wr_valid,
  output logic     wr_ready,
  input  logic     pop,
  output logic     full,
  output sc_byte_t rd_data
);

  logic     full_q;
  sc_byte_t data_q;

  assign wr_ready = ~full_q;
  assign full     = full_q;
  assign rd_data  = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
    end else if (wr_valid && !full_q) begin
      full_q <= 1'b1;
    end else if (pop) begin
      full_q <= 1'b0;
    end
  end

  // data register carries no reset
  always_ff @(posedge clk) begin
    if (wr_valid && !full_q) begin
      data_q <= wr_data;
    end
  end

endmodule

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
  parameter int ETU_CLKS = 372
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic etu_end,
  output logic half_hit,
  output logic late_half
);

  localparam int CNT_W = (ETU_CLKS > 2) ? $clog2(ETU_CLKS) : 1;
  localparam int HALF  = ETU_CLKS / 2;
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(ETU_CLKS - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF);

  logic [CNT_W-1:0] cnt_q;

  assign etu_end   = run && (cnt_q == CNT_TOP);
  assign half_hit  = run && (cnt_q == CNT_HALF);
  assign late_half = run && (cnt_q >= CNT_HALF);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= etu_end ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sc_frame_tx.sv
module sc_frame_tx
  import sc_tx_pkg::*;
#(
  parameter int STOP_ETU = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     go_ok,
  input  sc_byte_t hold_data,
  input  logic     inv_fmt,
  input  logic     etu_end,
  output logic     load,
  output logic     busy,
  output logic     err_window,
  output logic     tx_line,
  output logic     txe,
  output logic     tx_irq
);

  localparam int SLOTS  = SC_DATA_W + 2 + STOP_ETU;
  localparam int SLOT_W = $clog2(SLOTS + 1);
  localparam logic [SLOT_W-1:0] LAST_S  = SLOT_W'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] DATA_S  = SLOT_W'(SC_DATA_W);
  localparam logic [SLOT_W-1:0] PAR_S   = SLOT_W'(SC_DATA_W + 1);
  localparam logic [SLOT_W-1:0] GUARD_S = SLOT_W'(SC_DATA_W + 2);

  logic [SLOT_W-1:0] slot_q, nxt;
  sc_byte_t          word_q;
  logic              par_q, busy_q, tx_q, txe_q, irq_q;
  logic              frame_end, next_bit;

  assign nxt        = slot_q + 1'b1;
  assign frame_end  = busy_q && etu_end && (slot_q == LAST_S);
  assign load       = go_ok && (!busy_q || frame_end);
  assign busy       = busy_q;
  assign err_window = busy_q && (slot_q == GUARD_S);
  assign tx_line    = tx_q;
  assign txe        = txe_q;
  assign tx_irq     = irq_q;

  always_comb begin
    next_bit = 1'b1;
    if (nxt <= DATA_S) begin
      next_bit = word_q[0];
    end else if (nxt == PAR_S) begin
      next_bit = par_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      word_q <= '0;
      par_q  <= 1'b0;
      tx_q   <= 1'b1;
      txe_q  <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (load) begin
        busy_q <= 1'b1;
        txe_q  <= 1'b0;
        slot_q <= '0;
        word_q <= sc_line_word(hold_data, inv_fmt);
        par_q  <= sc_line_parity(hold_data);
        tx_q   <= 1'b0;
        irq_q  <= frame_end;
      end else if (frame_end) begin
        busy_q <= 1'b0;
        txe_q  <= 1'b1;
        irq_q  <= 1'b1;
        tx_q   <= 1'b1;
        slot_q <= '0;
      end else if (busy_q && etu_end) begin
        slot_q <= nxt;
        tx_q   <= next_bit;
        if (nxt <= DATA_S) begin
          word_q <= word_q >> 1;
        end
      end
    end
  end

endmodule

// File: rtl/sc_err_det.sv
module sc_err_det (
  input  logic clk,
  input  logic rst,
  input  logic sample,
  input  logic rx_line,
  input  logic err_clr,
  output logic par_err
);

  logic err_q;

  assign par_err = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
    end else begin
      err_q <= (sample && !rx_line) || (err_q && !err_clr);
    end
  end

endmodule

// File: rtl/sc_uart_tx.sv
module sc_uart_tx
  import sc_tx_pkg::*;
#(
  parameter int ETU_CLKS = 372,
  parameter int STOP_ETU = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tx_en,
  input  logic                 rx_en,
  input  logic                 inv_fmt,
  input  logic [SC_DATA_W-1:0] in_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 rx_line,
  input  logic                 err_clr,
  output logic                 tx_line,
  output logic                 sck,
  output logic                 txe,
  output logic                 tx_irq,
  output logic                 par_err
);

  logic     hold_full, load, busy, err_window;
  logic     etu_end, half_hit, late_half;
  sc_byte_t hold_data;
  logic     sck_q;

  sc_hold_buf u_hold (
    .clk      (clk),
    .rst      (rst),
    .wr_data  (in_data),
    .wr_valid (in_valid),
    .wr_ready (in_ready),
    .pop      (load),
    .full     (hold_full),
    .rd_data  (hold_data)
  );

  sc_etu_timer #(.ETU_CLKS(ETU_CLKS)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart   (load),
    .run       (busy),
    .etu_end   (etu_end),
    .half_hit  (half_hit),
    .late_half (late_half)
  );

  sc_frame_tx #(.STOP_ETU(STOP_ETU)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .go_ok      (hold_full && tx_en && rx_en),
    .hold_data  (hold_data),
    .inv_fmt    (inv_fmt),
    .etu_end    (etu_end),
    .load       (load),
    .busy       (busy),
    .err_window (err_window),
    .tx_line    (tx_line),
    .txe        (txe),
    .tx_irq     (tx_irq)
  );

  sc_err_det u_err (
    .clk     (clk),
    .rst     (rst),
    .sample  (err_window && half_hit),
    .rx_line (rx_line),
    .err_clr (err_clr),
    .par_err (par_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b1;
    end else begin
      sck_q <= ~late_half;
    end
  end

  assign sck = sck_q;

endmodule

// File: rtl/sc_uart_tx_chk.sv
module sc_uart_tx_chk (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic rx_en,
  input logic in_valid,
  input logic in_ready,
  input logic err_clr,
  input logic tx_line,
  input logic sck,
  input logic txe,
  input logic tx_irq,
  input logic par_err
);

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $fell(txe) |-> $past(tx_en && rx_en));                        // R3
  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(txe) |-> !tx_line);                                     // R3
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    txe |-> tx_line);                                             // R5
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    tx_irq |=> !tx_irq);                                          // R8
  AST_CHAIN_OR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> (txe || !tx_line));                                // R9
  AST_SLOT_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);                        // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (par_err && !err_clr) |=> par_err);                           // R11
  AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (txe && $past(txe)) |-> sck);                                 // R12

endmodule

bind sc_uart_tx sc_uart_tx_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tx_en    (tx_en),
  .rx_en    (rx_en),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .err_clr  (err_clr),
  .tx_line  (tx_line),
  .sck      (sck),
  .txe      (txe),
  .tx_irq   (tx_irq),
  .par_err  (par_err)
);

// File: tb/sc_uart_tx_tb.sv
`timescale 1ns/1ps
module sc_uart_tx_tb;

  localparam int ETU   = 16;
  localparam int HALF  = ETU / 2;
  localparam int SLOTS = 12;

  logic clk = 1'b0;
  logic rst, tx_en, rx_en, inv_fmt, in_valid, rx_line, err_clr;
  logic [7:0] in_data;
  logic in_ready, tx_line, sck, txe, tx_irq, par_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  sc_uart_tx #(.ETU_CLKS(ETU), .STOP_ETU(2)) u_dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .inv_fmt(inv_fmt),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .rx_line(rx_line), .err_clr(err_clr), .tx_line(tx_line), .sck(sck),
    .txe(txe), .tx_irq(tx_irq), .par_err(par_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         pos;
  bit         hf, cinv, m_txe, m_irq, m_err, m_sck;
  logic [7:0] hd, cur;
  int         p_o;
  bit         busy_o, hf_o, fend, go, smp;
  logic [7:0] hd_o;

  function automatic bit exp_line();
    int s;
    int ones;
    if (pos < 0) return 1'b1;
    s = pos / ETU;
    if (s == 0) return 1'b0;
    if (s <= 8) return cinv ? ~cur[8-s] : cur[s-1];
    if (s == 9) begin
      ones = 0;
      for (int k = 0; k < 8; k++) ones += (cinv ? ~cur[k] : cur[k]);
      return ones % 2;
    end
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      pos = -1; hf = 0; m_txe = 1; m_irq = 0; m_err = 0; m_sck = 1; cinv = 0; cur = 0;
    end else begin
      p_o = pos; busy_o = (p_o >= 0); hf_o = hf; hd_o = hd;
      m_sck = !(busy_o && (p_o % ETU) >= HALF);
      smp   = busy_o && (p_o / ETU) == 10 && (p_o % ETU) == HALF && !rx_line;
      m_err = smp || (m_err && !err_clr);
      fend  = busy_o && (p_o == SLOTS*ETU - 1);
      go    = hf_o && tx_en && rx_en && (!busy_o || fend);
      m_irq = fend;
      if (go) begin
        pos = 0; cur = hd_o; cinv = inv_fmt; hf = 0; m_txe = 0;
      end else if (fend) begin
        pos = -1; m_txe = 1;
      end else if (busy_o) begin
        pos = p_o + 1;
      end
      if (in_valid && !hf_o) begin
        hf = 1; hd = in_data;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(tx_line === exp_line(), cinv ? "R7" : "R5", "tx_line", tx_line, exp_line());
      chk(sck === m_sck, "R12", "sck", sck, m_sck);
      chk(txe === m_txe, "R8", "txe", txe, m_txe);
      chk(tx_irq === m_irq, "R8", "tx_irq", tx_irq, m_irq);
      chk(par_err === m_err, "R10", "par_err", par_err, m_err);
      chk(in_ready === !hf, "R2", "in_ready", in_ready, !hf);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic push(input logic [7:0] b);
    @(negedge clk);
    in_data = b; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!txe) @(negedge clk);
  endtask

  task automatic wait_start();
    while (tx_line !== 1'b0) @(negedge clk);
  endtask

  // samples every slot at mid-ETU and checks it against the frame built from b
  task automatic capture(input logic [7:0] b, input bit inv, input bit at_start);
    int ones;
    bit e;
    if (!at_start) wait_start();
    repeat (HALF) @(negedge clk);
    ones = 0;
    for (int s = 0; s < SLOTS; s++) begin
      if (s > 0) repeat (ETU) @(negedge clk);
      if (s == 0) e = 1'b0;
      else if (s <= 8) begin
        e = inv ? ~b[8-s] : b[s-1];
        ones += e;
      end else if (s == 9) e = ones % 2;
      else e = 1'b1;
      chk(tx_line === e, (s == 9) ? "R6" : ((s >= 1 && s <= 8 && inv) ? "R7" : "R5"),
          "frame slot", tx_line, e);
    end
  endtask

  task automatic err_window(input int off, input bit exp, input bit clr_too);
    push(8'hC3);
    wait_start();
    repeat (10*ETU + HALF + off) @(negedge clk);
    rx_line = 1'b0;
    if (clr_too) err_clr = 1'b1;
    @(negedge clk);
    rx_line = 1'b1; err_clr = 1'b0;
    wait_idle();
    chk(par_err === exp, clr_too ? "R11" : "R10", "par_err after window", par_err, exp);
  endtask

  // ---------------- scenarios ----------------
  initial begin
    int n;
    rst = 1; tx_en = 0; rx_en = 0; inv_fmt = 0; in_valid = 0; in_data = 0;
    rx_line = 1; err_clr = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(tx_line === 1'b1, "R1", "tx_line", tx_line, 1);
    chk(sck === 1'b1, "R1", "sck", sck, 1);
    chk(txe === 1'b1, "R1", "txe", txe, 1);
    chk(in_ready === 1'b1, "R1", "in_ready", in_ready, 1);
    chk(tx_irq === 1'b0, "R1", "tx_irq", tx_irq, 0);
    chk(par_err === 1'b0, "R1", "par_err", par_err, 0);

    // R3: a held byte waits while either enable is low
    rx_en = 1;
    push(8'h5A);
    repeat (3*ETU) @(negedge clk);
    chk(txe === 1'b1 && tx_line === 1'b1, "R3", "no start, tx_en low", txe, 1);
    chk(in_ready === 1'b0, "R2", "slot stays full", in_ready, 0);
    tx_en = 1; rx_en = 0;
    repeat (3*ETU) @(negedge clk);
    chk(txe === 1'b1 && tx_line === 1'b1, "R3", "no start, rx_en low", txe, 1);
    rx_en = 1;
    capture(8'h5A, 0, 0);
    wait_idle();

    // R4: start bit width, using an LSB of 1
    push(8'h01);
    wait_start();
    n = 0;
    while (tx_line === 1'b0) begin n++; @(negedge clk); end
    chk(n == ETU, "R4", "start bit clocks", n, ETU);
    wait_idle();

    // R9: back-to-back frames
    push(8'h00);
    push(8'hFF);
    capture(8'h00, 0, 0);
    while (!tx_irq) @(negedge clk);
    chk(tx_line === 1'b0 && txe === 1'b0, "R9", "chained start bit", tx_line, 0);
    capture(8'hFF, 0, 1);
    wait_idle();

    // R7: inverse convention
    inv_fmt = 1;
    push(8'h3B);
    capture(8'h3B, 1, 0);
    wait_idle();
    push(8'h80);
    capture(8'h80, 1, 0);
    wait_idle();
    inv_fmt = 0;

    // R10: the one-clock sample window
    err_window(-1, 1'b0, 1'b0);
    err_window(1, 1'b0, 1'b0);
    err_window(0, 1'b1, 1'b0);
    // R11: a new error on the clear clock keeps the flag set
    err_window(0, 1'b1, 1'b1);
    repeat (2*ETU) @(negedge clk);
    chk(par_err === 1'b1, "R11", "sticky flag", par_err, 1);
    err_clr = 1; @(negedge clk); err_clr = 0;
    chk(par_err === 1'b0, "R11", "flag cleared", par_err, 0);

    // R13: enable dropped mid-frame
    push(8'hA7);
    wait_start();
    n = 0;
    while (!tx_irq && n < 2*SLOTS*ETU) begin
      @(negedge clk);
      n++;
      if (n == 2*ETU) tx_en = 0;
    end
    chk(n == SLOTS*ETU, "R13", "frame length with tx_en dropped", n, SLOTS*ETU);
    chk(txe === 1'b1, "R13", "txe after frame", txe, 1);
    tx_en = 1;
    repeat (ETU) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule